// File: doc/BRIEF.md
# Registered Sum-of-Products Plane

This block evaluates one fixed Boolean function written as an OR of product terms. Every input bit is first captured in a register that drives two rails, the bit and its complement. All logic after those registers is non-inverting. A set of product rows each ANDs the literals chosen for it, and a single wide OR merges the rows into a registered output bit. The function is therefore a Boolean matrix-vector product followed by an OR-reduction over the resulting row vector.

The function is fixed at elaboration through a configuration parameter. It holds two bits per input per row. The block is used wherever a small custom decode or match function must be built from a regular, two-level array instead of free-form gates.

Top module: `sop_plane`

## Requirements
- R1: A value applied on `in_vec` before clock edge k affects `out_bit` starting right after edge k+1. There is one register stage at the input and one at the output, and no combinational path exists from input to output.
- R2: Literal code 2'b01 in a row selects the true rail of that input, so the row can only be 1 when that input was 1.
- R3: Literal code 2'b10 in a row selects the complemented rail of that input, so the row can only be 1 when that input was 0.
- R4: Literal code 2'b00 leaves the input out of the row. A row whose codes are all 2'b00 is constant 1, which makes the output 1 in every cycle after reset.
- R5: Literal code 2'b11 in any position forces that row to 0, whatever the inputs.
- R6: When every row contains at least one 2'b11 code, `out_bit` is 0 in every cycle.
- R7: `out_bit` equals the OR over all rows of the AND of their selected literals, for every input combination. The code for input i of row r sits at `CFG[(r*N_IN+i)*2 +: 2]`.
- R8: While `rst` is high at a clock edge, both rails of every input register and `out_bit` are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | N_IN | Input variables of the function |
| out_bit | output | 1 | Registered function value |

## Verification
Four instances with different configurations receive the same stimulus. The first pass walks all sixteen input combinations in order, followed by random vectors from a fixed seed. The mixed XOR-style configuration tells the true rail apart from the complemented rail. A configuration with negated literals on three inputs catches swapped or misplaced code fields. The all-disabled and empty-row configurations separate the forced-zero code from the don't-care code. Because every comparison uses the vector applied two edges earlier, any change in pipeline depth shows up, and a reset in mid-run must clear the output.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Two-bit literal selector, one per input per product row
    typedef enum logic [1:0] {
        LIT_SKIP = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_KILL = 2'b11
    } lit_sel_e;

    localparam int unsigned LIT_W = 2;

endpackage

// File: rtl/sop_dual_rail_reg.sv
module sop_dual_rail_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] true_o,
    output logic [WIDTH-1:0] comp_o
);

    typedef struct packed {
        logic [WIDTH-1:0] pos;
        logic [WIDTH-1:0] neg;
    } rail_t;

    rail_t st_d, st_q;

    // The only inversion in the block happens here, in front of the flops
    always_comb begin
        st_d     = st_q;
        st_d.pos = d_i;
        st_d.neg = ~d_i;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign true_o = st_q.pos;
    assign comp_o = st_q.neg;

    // R1: each rail pair reflects the port value from the previous edge
    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (true_o == $past(d_i)));

    a_r3_rails_opposite: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (comp_o == ~$past(d_i)));

    // R8: reset leaves both rails at zero
    a_r8_rails_cleared: assert property (@(posedge clk)
        rst |=> (true_o == '0) && (comp_o == '0));

endmodule

// File: rtl/sop_product_row.sv
module sop_product_row
    import sop_pkg::*;
#(
    parameter int unsigned           N_IN    = 4,
    parameter logic [2*N_IN-1:0]     ROW_CFG = '0
) (
    input  logic [N_IN-1:0] true_i,
    input  logic [N_IN-1:0] comp_i,
    output logic            hit_o
);

    // Wide AND over the chosen rails; selection is fixed by the parameter
    always_comb begin
        hit_o = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            unique case (lit_sel_e'(ROW_CFG[i*LIT_W +: LIT_W]))
                LIT_TRUE: hit_o = hit_o & true_i[i];
                LIT_COMP: hit_o = hit_o & comp_i[i];
                LIT_KILL: hit_o = 1'b0;
                default:  hit_o = hit_o;
            endcase
        end
    end

endmodule

// File: rtl/sop_or_stage.sv
module sop_or_stage #(
    parameter int unsigned N_ROWS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ROWS-1:0] rows_i,
    output logic              out_o
);

    typedef struct packed {
        logic val;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.val = |rows_i;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_o = st_q.val;

    // R8: output register cleared by reset
    a_r8_out_cleared: assert property (@(posedge clk)
        rst |=> (out_o == 1'b0));

endmodule

// File: rtl/sop_plane.sv
module sop_plane
    import sop_pkg::*;
#(
    parameter int unsigned                N_IN   = 4,
    parameter int unsigned                N_ROWS = 4,
    parameter logic [2*N_IN*N_ROWS-1:0]   CFG    = 32'h0350_0609
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] in_vec,
    output logic            out_bit
);

    localparam int unsigned ROW_BITS = LIT_W * N_IN;

    // A row is dead if any of its codes is the kill code
    function automatic logic row_dead(input int unsigned r);
        logic dead;
        dead = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (CFG[r*ROW_BITS + i*LIT_W +: LIT_W] == LIT_KILL) dead = 1'b1;
        end
        return dead;
    endfunction

    function automatic logic row_empty(input int unsigned r);
        return CFG[r*ROW_BITS +: ROW_BITS] == '0;
    endfunction

    function automatic logic all_dead();
        logic d;
        d = 1'b1;
        for (int r = 0; r < N_ROWS; r++) d = d & row_dead(r);
        return d;
    endfunction

    function automatic logic any_empty();
        logic e;
        e = 1'b0;
        for (int r = 0; r < N_ROWS; r++) e = e | row_empty(r);
        return e;
    endfunction

    localparam logic ALL_DEAD  = all_dead();
    localparam logic ANY_EMPTY = any_empty();

    logic [N_IN-1:0]   rail_true;
    logic [N_IN-1:0]   rail_comp;
    logic [N_ROWS-1:0] row_hit;

    sop_dual_rail_reg #(.WIDTH(N_IN)) u_inreg (
        .clk    (clk),
        .rst    (rst),
        .d_i    (in_vec),
        .true_o (rail_true),
        .comp_o (rail_comp)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        sop_product_row #(
            .N_IN    (N_IN),
            .ROW_CFG (CFG[r*ROW_BITS +: ROW_BITS])
        ) u_row (
            .true_i (rail_true),
            .comp_i (rail_comp),
            .hit_o  (row_hit[r])
        );

        if (row_dead(r)) begin : g_dead_chk
            // R5: a row carrying the kill code never fires
            a_r5_row_killed: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (row_hit[r] == 1'b0));
        end
    end

    sop_or_stage #(.N_ROWS(N_ROWS)) u_or (
        .clk    (clk),
        .rst    (rst),
        .rows_i (row_hit),
        .out_o  (out_bit)
    );

    if (ALL_DEAD) begin : g_all_dead_chk
        // R6: with every row killed the output stays low
        a_r6_all_off: assert property (@(posedge clk)
            1'b1 |=> (out_bit == 1'b0));
    end

    if (ANY_EMPTY) begin : g_empty_chk
        // R4: an empty row holds the output high once out of reset
        a_r4_empty_row: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (out_bit == 1'b1));
    end

endmodule

// File: tb/tb_sop_plane.sv
module tb_sop_plane;

    localparam int unsigned N_IN   = 4;
    localparam int unsigned N_ROWS = 4;
    localparam logic [31:0] CFG_A = 32'h0350_0609; // x0^x1 | x2&x3, row3 killed
    localparam logic [31:0] CFG_B = 32'h0303_0303; // every row killed
    localparam logic [31:0] CFG_C = 32'h0303_0300; // row0 empty
    localparam logic [31:0] CFG_D = 32'h1803_8025; // mixed polarity

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_vec = '0;
    logic       out_a, out_b, out_c, out_d;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sop_plane #(.N_IN(N_IN), .N_ROWS(N_ROWS), .CFG(CFG_A)) dut (
        .clk(clk), .rst(rst), .in_vec(in_vec), .out_bit(out_a));
    sop_plane #(.N_IN(N_IN), .N_ROWS(N_ROWS), .CFG(CFG_B)) dut_b (
        .clk(clk), .rst(rst), .in_vec(in_vec), .out_bit(out_b));
    sop_plane #(.N_IN(N_IN), .N_ROWS(N_ROWS), .CFG(CFG_C)) dut_c (
        .clk(clk), .rst(rst), .in_vec(in_vec), .out_bit(out_c));
    sop_plane #(.N_IN(N_IN), .N_ROWS(N_ROWS), .CFG(CFG_D)) dut_d (
        .clk(clk), .rst(rst), .in_vec(in_vec), .out_bit(out_d));

    // Software model of the two-level plane from the literal encoding
    function automatic logic model(input logic [31:0] cfg, input logic [3:0] v);
        logic acc;
        acc = 1'b0;
        for (int r = 0; r < 4; r++) begin
            logic prod;
            prod = 1'b1;
            for (int i = 0; i < 4; i++) begin
                case (cfg[(r*4+i)*2 +: 2])
                    2'b01:   prod = prod & v[i];
                    2'b10:   prod = prod & ~v[i];
                    2'b11:   prod = 1'b0;
                    default: prod = prod;
                endcase
            end
            acc = acc | prod;
        end
        return acc;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    logic [3:0] hist1, hist2;
    int         valid;

    task automatic step(input logic [3:0] v);
        @(negedge clk);
        if (valid >= 2) begin
            check("R1 R2 R7 xor-style", out_a, model(CFG_A, hist2));
            check("R5 R6 all killed",   out_b, model(CFG_B, hist2));
            check("R4 empty row",       out_c, model(CFG_C, hist2));
            check("R3 R7 mixed",        out_d, model(CFG_D, hist2));
        end
        hist2  = hist1;
        hist1  = v;
        in_vec = v;
        valid++;
    endtask

    task automatic reset_and_check();
        @(negedge clk);
        rst = 1'b1;
        in_vec = 4'hF;
        @(negedge clk);
        check("R8 reset a", out_a, 1'b0);
        check("R8 reset b", out_b, 1'b0);
        check("R8 reset c", out_c, 1'b0);
        check("R8 reset d", out_d, 1'b0);
        rst   = 1'b0;
        valid = 0;
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        valid = 0;
        hist1 = '0;
        hist2 = '0;
        repeat (2) @(negedge clk);
        check("R8 initial reset a", out_a, 1'b0);
        check("R8 initial reset c", out_c, 1'b0);
        rst = 1'b0;

        // Exhaustive pass, in order and then reversed
        for (int k = 0; k < 16; k++) step(4'(k));
        for (int k = 15; k >= 0; k--) step(4'(k));

        // Directed: alternate extremes to expose rail swaps
        step(4'h0); step(4'hF); step(4'h0); step(4'hF); step(4'h5); step(4'hA);

        // Mid-run reset
        reset_and_check();

        seed = 32'd1234;
        void'($urandom(seed));
        for (int k = 0; k < 300; k++) step(4'($urandom()));
        step(4'h0); step(4'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule